// File: doc/BRIEF.md
# Calendar Clock with Second Trim

This block keeps wall-clock time and calendar date from a once-per-second enable pulse. It holds seven binary counters: second, minute, hour, weekday, day of month, month and an 8-bit year. Each tick advances the time by one second. Carries run through every field, and the month length follows the month and a leap rule based on the year. A small register bus lets a host set any field directly and read back any field in the same cycle.

Drift correction uses one write-only trim register. Writing the advance code arms a correction that makes the next tick move the time forward by two seconds. Writing the retard code arms a correction that makes the next tick leave the time unchanged. A small controller arms, applies and then locks out corrections. Its states are `ST_IDLE` (nothing pending), `ST_ADV` (advance armed), `ST_RET` (retard armed) and `ST_LOCK` (counting ticks after a correction).

The controller moves between states as follows:
- `ST_IDLE` goes to `ST_ADV` or `ST_RET` on a valid trim write.
- `ST_ADV` and `ST_RET` go to `ST_LOCK` on a tick, which applies the correction.
- `ST_ADV` and `ST_RET` go back to `ST_IDLE` on any field write, which cancels the correction.
- `ST_LOCK` goes back to `ST_IDLE` once the lockout count of ticks has elapsed.

Top module: `cal_clock`

## Requirements
- R1: After reset the fields read as second 0, minute 0, hour 0, weekday 1, day 1, month 1, year 0, and no correction is armed.
- R2: A tick with no correction armed advances the second. The second rolls from 59 to 0 and carries into the minute. The minute rolls from 59 to 0 and carries into the hour. The hour rolls from 23 to 0 and carries into the day.
- R3: The weekday advances on each day carry and runs 1 to 7, wrapping from 7 back to 1.
- R4: The day of month rolls to 1 after its last day and carries into the month. The last day is 30 for months 4, 6, 9 and 11, and 31 for all other months except February. February has 29 days when the year is a multiple of 4, year 0 included, and 28 days otherwise. The month rolls from 12 to 1 and carries into the year, and the year wraps from 255 to 0.
- R5: Register addresses are: 0 second, 1 minute, 2 hour, 3 weekday, 4 day, 5 month, 6 year, 7 trim. A write to addresses 0 to 6 replaces that field with the low bits of the write data by the next cycle. A read returns the field zero-extended. Address 7 and addresses 8 to 15 read as 0.
- R6: Writing value 01 to bits [1:0] of address 7 while idle arms an advance. The next tick then advances the time by two seconds, with full carries.
- R7: Writing value 10 to bits [1:0] of address 7 while idle arms a retard. The next tick then leaves every field unchanged.
- R8: A trim write with bits [1:0] equal to 11 or 00 has no effect.
- R9: After a correction tick, trim writes are ignored until two further ticks have occurred. A trim write during an armed correction is also ignored.
- R10: A write to any field cancels an armed correction. A tick arriving in the same cycle as a field write is not applied to any field.
- R11: Without a tick or a write, every field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | 8 | Read data of the addressed field |

## Verification
Two coincidences matter most. The first is a tick landing in the same cycle as a field write, where the write must win, the tick must be lost and an armed correction must be cancelled. The second is a tick landing in the same cycle as a trim write, where the tick must advance normally and the trim must arm for the following tick. Directed steps place these pulses in one cycle. A long random phase mixes them freely. A behavioural reference model checks each resulting field on every clock and tracks the pending and lockout state on its own.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef struct packed {
        logic [7:0] yr;
        logic [3:0] mo;
        logic [4:0] date;
        logic [2:0] dow;
        logic [4:0] hr;
        logic [5:0] mn;
        logic [5:0] sec;
    } cal_time_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADV  = 2'd1,
        ST_RET  = 2'd2,
        ST_LOCK = 2'd3
    } trim_state_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_ONE  = 2'd1,
        STEP_TWO  = 2'd2
    } step_sel_t;

    localparam int N_STAGE = 2;

    localparam logic [5:0] SEC_LAST = 6'd59;
    localparam logic [5:0] MIN_LAST = 6'd59;
    localparam logic [4:0] HR_LAST  = 5'd23;
    localparam logic [2:0] DOW_LAST = 3'd7;
    localparam logic [3:0] MO_LAST  = 4'd12;

    localparam int A_SEC  = 0;
    localparam int A_MIN  = 1;
    localparam int A_HR   = 2;
    localparam int A_DOW  = 3;
    localparam int A_DATE = 4;
    localparam int A_MO   = 5;
    localparam int A_YR   = 6;
    localparam int A_TRIM = 7;

    localparam logic [1:0] TRIM_ADV = 2'b01;
    localparam logic [1:0] TRIM_RET = 2'b10;

    localparam cal_time_t CAL_RESET = '{yr: 8'd0, mo: 4'd1, date: 5'd1, dow: 3'd1,
                                        hr: 5'd0, mn: 6'd0, sec: 6'd0};

endpackage

// File: rtl/cal_month_len.sv
module cal_month_len (
    input  logic [3:0] month,
    input  logic [7:0] year,
    output logic [4:0] days
);
    logic leap;

    assign leap = (year[1:0] == 2'b00);

    always_comb begin
        case (month)
            4'd2:                    days = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: days = 5'd30;
            default:                 days = 5'd31;
        endcase
    end
endmodule

// File: rtl/cal_step.sv
module cal_step
    import cal_pkg::*;
(
    input  cal_time_t cur,
    output cal_time_t nxt
);
    logic [4:0] mlen;
    logic       roll_s, roll_m, roll_h, roll_d, roll_mo;

    cal_month_len u_len (
        .month (cur.mo),
        .year  (cur.yr),
        .days  (mlen)
    );

    assign roll_s  = (cur.sec >= SEC_LAST);
    assign roll_m  = roll_s && (cur.mn >= MIN_LAST);
    assign roll_h  = roll_m && (cur.hr >= HR_LAST);
    assign roll_d  = roll_h && (cur.date >= mlen);
    assign roll_mo = roll_d && (cur.mo >= MO_LAST);

    always_comb begin
        nxt.sec  = roll_s ? 6'd0 : cur.sec + 6'd1;
        nxt.mn   = roll_s ? (roll_m ? 6'd0 : cur.mn + 6'd1) : cur.mn;
        nxt.hr   = roll_m ? (roll_h ? 5'd0 : cur.hr + 5'd1) : cur.hr;
        nxt.dow  = roll_h ? ((cur.dow >= DOW_LAST) ? 3'd1 : cur.dow + 3'd1) : cur.dow;
        nxt.date = roll_h ? (roll_d ? 5'd1 : cur.date + 5'd1) : cur.date;
        nxt.mo   = roll_d ? (roll_mo ? 4'd1 : cur.mo + 4'd1) : cur.mo;
        nxt.yr   = roll_mo ? cur.yr + 8'd1 : cur.yr;
    end
endmodule

// File: rtl/cal_trim_fsm.sv
module cal_trim_fsm
    import cal_pkg::*;
#(
    parameter int LOCK_TICKS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        field_wr,
    input  logic        trim_wr,
    input  logic [1:0]  trim_req,
    output step_sel_t   sel,
    output trim_state_t state_q
);
    localparam int CNT_W = $clog2(LOCK_TICKS + 1);

    trim_state_t      state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trim_wr) begin
                    if (trim_req == TRIM_ADV)      state_d = ST_ADV;
                    else if (trim_req == TRIM_RET) state_d = ST_RET;
                end
            end
            ST_ADV, ST_RET: begin
                if (field_wr) begin
                    state_d = ST_IDLE;
                end else if (tick) begin
                    state_d = ST_LOCK;
                    cnt_d   = CNT_W'(LOCK_TICKS);
                end
            end
            ST_LOCK: begin
                if (tick) begin
                    if (cnt_q <= CNT_W'(1)) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sel = STEP_ONE;
        if (!tick || field_wr) begin
            sel = STEP_HOLD;
        end else begin
            unique case (state_q)
                ST_ADV:  sel = STEP_TWO;
                ST_RET:  sel = STEP_HOLD;
                default: sel = STEP_ONE;
            endcase
        end
    end
endmodule

// File: rtl/cal_clock.sv
module cal_clock
    import cal_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int LOCK_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata
);
    cal_time_t                t_q, t_d;
    cal_time_t [N_STAGE:0]    stage;
    step_sel_t                sel;
    trim_state_t              trim_state;
    logic                     field_wr, trim_wr;

    assign field_wr = bus_we && (bus_addr <= ADDR_W'(A_YR));
    assign trim_wr  = bus_we && (bus_addr == ADDR_W'(A_TRIM));

    assign stage[0] = t_q;

    for (genvar g = 0; g < N_STAGE; g++) begin : g_step
        cal_step u_step (
            .cur (stage[g]),
            .nxt (stage[g+1])
        );
    end

    cal_trim_fsm #(.LOCK_TICKS(LOCK_TICKS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1hz),
        .field_wr (field_wr),
        .trim_wr  (trim_wr),
        .trim_req (bus_wdata[1:0]),
        .sel      (sel),
        .state_q  (trim_state)
    );

    always_comb begin
        t_d = t_q;
        if (field_wr) begin
            case (bus_addr)
                ADDR_W'(A_SEC):  t_d.sec  = bus_wdata[5:0];
                ADDR_W'(A_MIN):  t_d.mn   = bus_wdata[5:0];
                ADDR_W'(A_HR):   t_d.hr   = bus_wdata[4:0];
                ADDR_W'(A_DOW):  t_d.dow  = bus_wdata[2:0];
                ADDR_W'(A_DATE): t_d.date = bus_wdata[4:0];
                ADDR_W'(A_MO):   t_d.mo   = bus_wdata[3:0];
                ADDR_W'(A_YR):   t_d.yr   = bus_wdata[7:0];
                default:         t_d      = t_q;
            endcase
        end else begin
            unique case (sel)
                STEP_ONE: t_d = stage[1];
                STEP_TWO: t_d = stage[N_STAGE];
                default:  t_d = t_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= CAL_RESET;
        else        t_q <= t_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(A_SEC):  bus_rdata[5:0] = t_q.sec;
            ADDR_W'(A_MIN):  bus_rdata[5:0] = t_q.mn;
            ADDR_W'(A_HR):   bus_rdata[4:0] = t_q.hr;
            ADDR_W'(A_DOW):  bus_rdata[2:0] = t_q.dow;
            ADDR_W'(A_DATE): bus_rdata[4:0] = t_q.date;
            ADDR_W'(A_MO):   bus_rdata[3:0] = t_q.mo;
            ADDR_W'(A_YR):   bus_rdata[7:0] = t_q.yr;
            default:         bus_rdata      = '0;
        endcase
    end
endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk
    import cal_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1hz,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input cal_time_t         t_q,
    input trim_state_t       trim_state
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !bus_we) |=> $stable(t_q)); // R11

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !bus_we && trim_state == ST_IDLE && t_q.sec < 6'd59)
        |=> (t_q.sec == 6'($past(t_q.sec) + 6'd1))); // R2

    AST_RETARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !bus_we && trim_state == ST_RET) |=> $stable(t_q)); // R7

    AST_WRITE_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(A_SEC)) |=> (t_q.sec == $past(bus_wdata[5:0]))); // R5

    AST_LOCK_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_state == ST_LOCK) |=> (trim_state != ST_ADV && trim_state != ST_RET)); // R9

    AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        ((trim_state == ST_ADV || trim_state == ST_RET) && bus_we && bus_addr <= ADDR_W'(A_YR))
        |=> (trim_state == ST_IDLE)); // R10

    AST_BOTH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_state == ST_IDLE && bus_we && bus_addr == ADDR_W'(A_TRIM) && bus_wdata[1:0] == 2'b11)
        |=> (trim_state == ST_IDLE)); // R8
endmodule

bind cal_clock cal_clock_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_1hz   (tick_1hz),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .t_q        (t_q),
    .trim_state (trim_state)
);

// File: tb/sim_cal_clock.sv
module sim_cal_clock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;

    always #10 clk = ~clk;

    cal_clock u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1hz  (tick_1hz),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata)
    );

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    bit    cmp_on = 1'b0;
    string phase = "R1";

    // reference model state; pend: 0 none, 1 advance, 2 retard
    int m_sec, m_min, m_hr, m_dow, m_date, m_mo, m_yr, m_pend, m_lock;

    function automatic int mdays(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic void m_step();
        if (m_sec < 59) begin m_sec++; return; end
        m_sec = 0;
        if (m_min < 59) begin m_min++; return; end
        m_min = 0;
        if (m_hr < 23) begin m_hr++; return; end
        m_hr = 0;
        m_dow = (m_dow >= 7) ? 1 : m_dow + 1;
        if (m_date < mdays(m_mo, m_yr)) begin m_date++; return; end
        m_date = 1;
        if (m_mo < 12) begin m_mo++; return; end
        m_mo = 1;
        m_yr = (m_yr + 1) % 256;
    endfunction

    function automatic int m_field(int a);
        case (a)
            0: return m_sec;
            1: return m_min;
            2: return m_hr;
            3: return m_dow;
            4: return m_date;
            5: return m_mo;
            6: return m_yr;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mo = 1; m_yr = 0;
            m_pend = 0; m_lock = 0;
        end else if (bus_we && bus_addr <= 4'd6) begin
            case (int'(bus_addr))
                0: m_sec  = bus_wdata % 64;
                1: m_min  = bus_wdata % 64;
                2: m_hr   = bus_wdata % 32;
                3: m_dow  = bus_wdata % 8;
                4: m_date = bus_wdata % 32;
                5: m_mo   = bus_wdata % 16;
                default: m_yr = bus_wdata;
            endcase
            m_pend = 0;
            if (tick_1hz && m_lock > 0) m_lock--;
        end else begin
            int pend_old, lock_old;
            pend_old = m_pend;
            lock_old = m_lock;
            if (tick_1hz) begin
                if (pend_old == 1) begin m_step(); m_step(); m_lock = 2; m_pend = 0; end
                else if (pend_old == 2) begin m_lock = 2; m_pend = 0; end
                else begin m_step(); if (m_lock > 0) m_lock--; end
            end
            if (bus_we && bus_addr == 4'd7 && pend_old == 0 && lock_old == 0) begin
                if (bus_wdata[1:0] == 2'b01) m_pend = 1;
                else if (bus_wdata[1:0] == 2'b10) m_pend = 2;
            end
        end
    end

    // one cycle: compare current read against the model, then drive new inputs
    task automatic cyc(input bit tk, input bit we, input int a, input int d);
        @(negedge clk);
        if (cmp_on) begin
            int exp_v;
            exp_v = m_field(int'(bus_addr));
            checks++;
            if (bus_rdata !== 8'(exp_v)) begin
                fails++;
                $display("FAIL %s addr=%0d actual=%0d expected=%0d", phase, bus_addr, bus_rdata, exp_v);
            end
        end
        tick_1hz  = tk;
        bus_we    = we;
        bus_addr  = 4'(a);
        bus_wdata = 8'(d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, i % 8, 0);
    endtask

    task automatic tick();
        cyc(1, 0, 0, 0);
        cyc(0, 0, 0, 0);
    endtask

    task automatic wr(input int a, input int d);
        cyc(0, 1, a, d);
    endtask

    task automatic chk_abs(input int a, input int v, input string req);
        cyc(0, 0, a, 0);
        #1;
        checks++;
        if (bus_rdata !== 8'(v)) begin
            fails++;
            $display("FAIL %s addr=%0d actual=%0d expected=%0d", req, a, bus_rdata, v);
        end
    endtask

    task automatic set_time(input int y, input int mo, input int dt, input int w,
                            input int h, input int mi, input int s);
        wr(6, y); wr(5, mo); wr(4, dt); wr(3, w); wr(2, h); wr(1, mi); wr(0, s);
        idle(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        phase = "R1";
        chk_abs(0, 0, "R1"); chk_abs(2, 0, "R1"); chk_abs(3, 1, "R1");
        chk_abs(4, 1, "R1"); chk_abs(5, 1, "R1"); chk_abs(6, 0, "R1");

        phase = "R11";
        idle(24);

        phase = "R2";
        set_time(3, 6, 10, 2, 23, 59, 58);
        tick();
        chk_abs(0, 59, "R2");
        tick();
        chk_abs(0, 0, "R2"); chk_abs(1, 0, "R2"); chk_abs(2, 0, "R2");
        chk_abs(4, 11, "R2");

        phase = "R3";
        set_time(3, 6, 12, 7, 23, 59, 59);
        tick();
        chk_abs(3, 1, "R3");

        phase = "R4";
        set_time(1, 2, 28, 1, 23, 59, 59); tick();
        chk_abs(4, 1, "R4"); chk_abs(5, 3, "R4");
        set_time(0, 2, 28, 1, 23, 59, 59); tick();
        chk_abs(4, 29, "R4"); chk_abs(5, 2, "R4");
        set_time(4, 2, 29, 1, 23, 59, 59); tick();
        chk_abs(4, 1, "R4"); chk_abs(5, 3, "R4");
        set_time(5, 4, 30, 1, 23, 59, 59); tick();
        chk_abs(4, 1, "R4"); chk_abs(5, 5, "R4");
        set_time(5, 1, 31, 1, 23, 59, 59); tick();
        chk_abs(5, 2, "R4");
        set_time(255, 12, 31, 1, 23, 59, 59); tick();
        chk_abs(6, 0, "R4"); chk_abs(5, 1, "R4"); chk_abs(4, 1, "R4");

        phase = "R5";
        wr(1, 8'hFF);
        chk_abs(1, 63, "R5");
        chk_abs(7, 0, "R5"); chk_abs(9, 0, "R5"); chk_abs(15, 0, "R5");

        phase = "R6";
        set_time(10, 12, 31, 3, 23, 59, 59);
        wr(7, 1); idle(2); tick();
        chk_abs(0, 1, "R6"); chk_abs(6, 11, "R6"); chk_abs(5, 1, "R6"); chk_abs(3, 4, "R6");
        tick(); tick();

        phase = "R7";
        set_time(10, 5, 5, 3, 10, 10, 30);
        wr(7, 2); tick();
        chk_abs(0, 30, "R7");
        tick();
        chk_abs(0, 31, "R7");
        tick();

        phase = "R8";
        wr(0, 20); wr(7, 3); tick();
        chk_abs(0, 21, "R8");
        wr(7, 0); tick();
        chk_abs(0, 22, "R8");

        phase = "R9";
        wr(7, 1); wr(7, 2); tick();
        chk_abs(0, 24, "R9");
        wr(7, 2); tick();
        chk_abs(0, 25, "R9");
        wr(7, 1); tick();
        chk_abs(0, 26, "R9");
        wr(7, 2); tick();
        chk_abs(0, 26, "R9");
        tick(); tick();

        phase = "R10";
        wr(0, 40);
        wr(7, 1); wr(0, 5); tick();
        chk_abs(0, 6, "R10");
        wr(1, 17);
        cyc(1, 1, 0, 44); idle(1);
        chk_abs(0, 44, "R10"); chk_abs(1, 17, "R10");
        cyc(1, 1, 7, 1); idle(1);
        chk_abs(0, 45, "R10");
        tick();
        chk_abs(0, 47, "R10");
        tick(); tick();

        phase = "R6/R9/R10 random";
        for (int i = 0; i < 6000; i++) begin
            int r, a, v;
            r = $urandom_range(0, 99);
            a = $urandom_range(0, 6);
            case (a)
                0, 1: v = $urandom_range(0, 59);
                2: v = $urandom_range(0, 23);
                3: v = $urandom_range(1, 7);
                4: v = $urandom_range(1, 28);
                5: v = $urandom_range(1, 12);
                default: v = $urandom_range(0, 255);
            endcase
            if (r < 25) cyc(1, 0, $urandom_range(0, 9), 0);
            else if (r < 33) cyc(0, 1, 7, $urandom_range(0, 3));
            else if (r < 36) cyc(1, 1, 7, $urandom_range(0, 3));
            else if (r < 38) cyc(0, 1, a, v);
            else if (r < 40) cyc(1, 1, a, v);
            else cyc(0, 0, $urandom_range(0, 9), 0);
        end
        idle(8);
        finish_run();
    end
endmodule